// File: doc/BRIEF.md
# Noise-Steered Alternating Step Bit Generator

This block turns a weak, possibly biased and correlated one-bit physical noise sample into a well-mixed random bit stream. It has two long linear feedback shift registers, A and B. On each clock a synchronised noise bit picks which of the two advances while the other holds. The output bit is the XOR of the two register output bits. In the classic alternating-step cipher a third register does this selecting; here the raw physical noise does it. A fresh output bit appears on every clock, so the throughput equals the clock rate.

Both registers are seeded in parallel through a load strobe. Seeds should have roughly as many ones as zeros. An all-zero seed is swapped for a fixed nonzero pattern so that neither register can lock up. The default build uses 127 and 129 stages with dense feedback masks, about half of whose coefficients are set and which are never trinomials. The two masks should be different irreducible polynomials whose periods are coprime. Lengths, masks and substitute patterns are all parameters.

Top module: `noise_asg`

## Requirements
- R1: While rst_ni is low, valid_o is 0, register A holds FIX_A, register B holds FIX_B and both synchroniser flops hold 0, so rnd_o equals FIX_A[LEN_A-1] ^ FIX_B[LEN_B-1].
- R2: On a clock edge with load_i low and select bit 1, register A steps as s <= {s[LEN_A-2:0], ^(s & TAPS_A)} and register B holds.
- R3: On a clock edge with load_i low and select bit 0, register B steps as s <= {s[LEN_B-2:0], ^(s & TAPS_B)} and register A holds.
- R4: rnd_o is, at all times, the XOR of the top bit of register A (bit LEN_A-1) and the top bit of register B (bit LEN_B-1) as they stand after the latest edge.
- R5: The select bit used at edge k+2 is the value noise_i had at edge k, carried through a two-flop synchroniser that shifts on every edge, including during load.
- R6: On each edge with load_i high, register A takes seed_a_i and register B takes seed_b_i, and neither steps.
- R7: A seed of all zeros loads FIX_A for register A, or FIX_B for register B, in its place.
- R8: valid_o is 0 after any edge at which load_i is high, and 0 after the first edge at which load_i is low following a load or reset. After every later edge it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one output bit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Parallel seed load strobe |
| seed_a_i | input | LEN_A | Seed for register A |
| seed_b_i | input | LEN_B | Seed for register B |
| noise_i | input | 1 | Asynchronous physical noise sample |
| rnd_o | output | 1 | Generated random bit |
| valid_o | output | 1 | rnd_o is usable |

## Verification
A noise sample reaches the select path two edges after it is driven. Its effect on the register state, and so on rnd_o, appears at the third edge. The bench keeps its own model of the two synchroniser flops and of both registers, and advances that model once per rising edge using the inputs it drove before that edge. It compares rnd_o and valid_o at the following falling edge. A load is visible at the first edge, and valid_o rises only at the second edge without load. The model ages a per-cycle hold flag in the same way, so every cycle of each sweep is compared at a settled point.

// File: rtl/asg_pkg.sv
package asg_pkg;
  typedef enum logic {
    SEL_B = 1'b0,
    SEL_A = 1'b1
  } asg_sel_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/asg_noise_sync.sv
module asg_noise_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= {q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/asg_lfsr.sv
module asg_lfsr #(
  parameter int unsigned       LEN  = 127,
  parameter logic [LEN-1:0]    TAPS = '1,
  parameter logic [LEN-1:0]    FIX  = LEN'(1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [LEN-1:0] seed_i,
  input  logic           step_i,
  output logic [LEN-1:0] state_o,
  output logic           msb_o
);
  logic [LEN-1:0] state_q;
  logic [LEN-1:0] seed_safe;
  logic           fb;

  assign seed_safe = (seed_i == '0) ? FIX : seed_i;  // lock-up guard
  assign fb        = ^(state_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     state_q <= FIX;
    else if (load_i) state_q <= seed_safe;
    else if (step_i) state_q <= {state_q[LEN-2:0], fb};

  assign state_o = state_q;
  assign msb_o   = state_q[LEN-1];
endmodule

// File: rtl/noise_asg.sv
module noise_asg
  import asg_pkg::*;
#(
  parameter int unsigned        LEN_A  = 127,
  parameter int unsigned        LEN_B  = 129,
  parameter logic [LEN_A-1:0]   TAPS_A = 127'h6B3D_94E2_A7C1_58F6_2D9B_E40C_735A_B1C7,
  parameter logic [LEN_B-1:0]   TAPS_B = 129'h1_9E4A_3C75_D2B8_0F63_A59C_E178_4D2B,
  parameter logic [LEN_A-1:0]   FIX_A  = 127'h5555_5555_5555_5555_5555_5555_5555_5555,
  parameter logic [LEN_B-1:0]   FIX_B  = 129'h0AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_A-1:0] seed_a_i,
  input  logic [LEN_B-1:0] seed_b_i,
  input  logic             noise_i,
  output logic             rnd_o,
  output logic             valid_o
);
  logic             sel_raw;
  asg_sel_e         sel;
  logic [LEN_A-1:0] state_a;
  logic [LEN_B-1:0] state_b;
  logic             msb_a, msb_b;
  logic             hold_q, valid_q;

  asg_noise_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (noise_i),
    .q_o    (sel_raw)
  );

  assign sel = asg_sel_e'(sel_raw);

  asg_lfsr #(.LEN(LEN_A), .TAPS(TAPS_A), .FIX(FIX_A)) u_reg_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .seed_i  (seed_a_i),
    .step_i  (sel == SEL_A),
    .state_o (state_a),
    .msb_o   (msb_a)
  );

  asg_lfsr #(.LEN(LEN_B), .TAPS(TAPS_B), .FIX(FIX_B)) u_reg_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .seed_i  (seed_b_i),
    .step_i  (sel == SEL_B),
    .state_o (state_b),
    .msb_o   (msb_b)
  );

  // first step after reset or load is flagged not valid
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hold_q  <= 1'b1;
      valid_q <= 1'b0;
    end else if (load_i) begin
      hold_q  <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      hold_q  <= 1'b0;
      valid_q <= ~hold_q;
    end

  assign rnd_o   = msb_a ^ msb_b;
  assign valid_o = valid_q;
endmodule

// File: rtl/asg_checker.sv
module asg_checker #(
  parameter int unsigned LEN_A = 127,
  parameter int unsigned LEN_B = 129
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             valid_o,
  input logic             sel_raw,
  input logic [LEN_A-1:0] state_a,
  input logic [LEN_B-1:0] state_b
);
  assert_load_no_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !valid_o);

  assert_post_load_no_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && $past(load_i)) |=> !valid_o);

  assert_sel_a_holds_b_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && sel_raw) |=> $stable(state_b));

  assert_sel_b_holds_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !sel_raw) |=> $stable(state_a));

  assert_no_zero_after_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (state_a != '0 && state_b != '0));
endmodule

bind noise_asg asg_checker #(.LEN_A(LEN_A), .LEN_B(LEN_B)) u_asg_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .valid_o (valid_o),
  .sel_raw (sel_raw),
  .state_a (state_a),
  .state_b (state_b)
);

// File: tb/noise_asg_test.sv
module noise_asg_test;
  localparam int unsigned LA = 7;
  localparam int unsigned LB = 9;
  localparam logic [LA-1:0] TA = 7'b110_0101;
  localparam logic [LB-1:0] TB = 9'b1_1011_0001;
  localparam logic [LA-1:0] FA = 7'h55;
  localparam logic [LB-1:0] FB = 9'h0AA;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [LA-1:0] seed_a = '0;
  logic [LB-1:0] seed_b = '0;
  logic          noise = 1'b0;
  logic          rnd, valid;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [LA-1:0] ma;
  logic [LB-1:0] mb;
  logic          s0, s1, mhold, mvalid;

  always #10 clk = ~clk;

  noise_asg #(.LEN_A(LA), .LEN_B(LB), .TAPS_A(TA), .TAPS_B(TB),
              .FIX_A(FA), .FIX_B(FB)) uut (
    .clk_i (clk), .rst_ni (rst_n), .load_i (load),
    .seed_a_i (seed_a), .seed_b_i (seed_b), .noise_i (noise),
    .rnd_o (rnd), .valid_o (valid)
  );

  task automatic check(input string tag, input logic act_r, input logic act_v);
    tests++;
    if (act_r !== (ma[LA-1] ^ mb[LB-1])) begin
      fails++;
      $display("FAIL %s rnd_o act=%b exp=%b", tag, act_r, ma[LA-1] ^ mb[LB-1]);
    end
    tests++;
    if (act_v !== mvalid) begin
      fails++;
      $display("FAIL R8 valid_o act=%b exp=%b (%s)", act_v, mvalid, tag);
    end
  endtask

  // drive, one edge, advance model, compare at falling edge
  task automatic cycle(input string tag, input logic ld, input logic [LA-1:0] sa,
                       input logic [LB-1:0] sb, input logic nz);
    logic sel;
    load = ld; seed_a = sa; seed_b = sb; noise = nz;
    @(posedge clk);
    sel = s1;
    s1 = s0;
    s0 = nz;
    if (ld) begin
      ma = (sa == '0) ? FA : sa;
      mb = (sb == '0) ? FB : sb;
      mhold = 1'b1; mvalid = 1'b0;
    end else begin
      if (sel) ma = {ma[LA-2:0], ^(ma & TA)};
      else     mb = {mb[LB-2:0], ^(mb & TB)};
      mvalid = ~mhold; mhold = 1'b0;
    end
    @(negedge clk);
    check(tag, rnd, valid);
  endtask

  function automatic logic pat(input int kind, input int i);
    case (kind)
      0: return 1'b1;
      1: return 1'b0;
      2: return i[0];
      3: return (i % 4) != 0;
      default: return 1'(((i * 37) >> 2) & 1);
    endcase
  endfunction

  initial begin
    logic [LA-1:0] sas [6];
    logic [LB-1:0] sbs [6];
    string tg;
    sas = '{7'h5A, 7'h00, 7'h33, 7'h7F, 7'h01, 7'h2C};
    sbs = '{9'h0F3, 9'h1A5, 9'h000, 9'h100, 9'h155, 9'h0C9};
    ma = FA; mb = FB; s0 = 0; s1 = 0; mhold = 1; mvalid = 0;
    repeat (3) @(negedge clk);
    check("R1", rnd, valid);
    rst_n = 1'b1;
    // free run from reset seeds, mixed noise
    for (int i = 0; i < 40; i++) cycle("R5", 1'b0, '0, '0, pat(4, i));
    for (int s = 0; s < 6; s++) begin
      for (int k = 0; k < 5; k++) begin
        tg = (sas[s] == '0 || sbs[s] == '0) ? "R7" : "R6";
        cycle(tg, 1'b1, sas[s], sbs[s], pat(k, 0));
        cycle(tg, 1'b1, sas[s], sbs[s], pat(k, 1));
        case (k)
          0: tg = "R2";
          1: tg = "R3";
          4: tg = "R4";
          default: tg = "R5";
        endcase
        for (int i = 2; i < 150; i++) cycle(tg, 1'b0, '0, '0, pat(k, i));
      end
    end
    // reset mid-stream returns to fixed patterns
    rst_n = 1'b0;
    #1;
    ma = FA; mb = FB; s0 = 0; s1 = 0; mhold = 1; mvalid = 0;
    @(negedge clk);
    check("R1", rnd, valid);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) cycle("R8", 1'b0, '0, '0, pat(2, i));
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule